// File: doc/BRIEF.md
# QDR-II Burst-2 SRAM Bridge

This block connects a synchronous 32-bit host port to a QDR-II SRAM organised as 2M x 18 with a burst length of two. The host issues reads and writes on separate active-low strobes. Each strobe has its own 22-bit byte address, and both may be issued in the same cycle. Every host word becomes one memory burst: a rising-edge beat and a falling-edge beat, each carrying 16 data bits and 2 parity bits. The DDR pad cells, echo-clock alignment and electrical levels are outside this block. Beats are exchanged as parallel rise/fall words, and the read address and write address appear as the rise and fall address words of the shared address bus.

Writes can cover a full word, a halfword or a single byte. The block passes host data and parity to the memory unchanged and turns the access size and the low address bits into active-low byte-write masks. On reads, the two returned beats are joined into one host word. Each byte is checked against its stored parity bit, and the result appears as a per-byte error flag. The read result arrives a fixed number of cycles after the request and is marked by a valid pulse. A parameter selects whether the host-side signals pass through a register stage in each direction.

Top module: `qdr2_bridge`

## Requirements
- R1: While reset is asserted and after it is released with no request, the memory read strobe, write strobe and all four byte-write masks are high, and host read valid and all error flags are low.
- R2: The memory word address is host byte address bits [21:2]. It is driven on the rise address word for a read and on the fall address word for a write.
- R3: A write with both size qualifiers low drives host data [15:0] with parity [1:0] on the rise beat and data [31:16] with parity [3:2] on the fall beat, with all four byte-write masks low.
- R4: A write with the 16-bit qualifier high drives both masks of one beat low and leaves the other beat's masks high. Host address bit 1 selects the beat (0 rise, 1 fall). Data lanes pass unchanged.
- R5: A write with the 8-bit qualifier high drives exactly one mask low. Host address bits [1:0] give the byte lane n: bit 1 of n selects the beat and bit 0 of n selects the mask within the beat. Data lanes pass unchanged.
- R6: Read data presented to the host is {fall beat, rise beat}, and a one-cycle valid pulse accompanies each read.
- R7: Error flag i is the XOR of host read data bits [8i+7:8i] with parity bit i, where rise beat parity bits 0/1 cover bytes 0/1 and fall beat parity bits 0/1 cover bytes 2/3. All flags are zero whenever valid is low.
- R8: Memory read beats are sampled at the MEM_LAT-th rising edge after the edge that drives the memory read strobe low. Host read valid rises MEM_LAT + 2 edges after the edge that samples the host read strobe when HOST_PIPE is 1, and MEM_LAT edges after it when HOST_PIPE is 0.
- R9: A read and a write sampled in the same host cycle are both issued to the memory in the same cycle, each with its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host and memory controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_addr_i | input | 22 | Write byte address |
| host_rd_addr_i | input | 22 | Read byte address |
| host_wr_data_i | input | 32 | Write data |
| host_wr_par_i | input | 4 | Write parity, bit i for byte i |
| host_rd_n_i | input | 1 | Read strobe, active low |
| host_wr_n_i | input | 1 | Write strobe, active low |
| host_sz16_i | input | 1 | Halfword write qualifier |
| host_sz8_i | input | 1 | Byte write qualifier |
| host_rd_data_o | output | 32 | Read data |
| host_par_err_o | output | 4 | Per-byte parity error flags |
| host_rd_valid_o | output | 1 | Read data valid pulse |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| mem_sa_rise_o | output | 20 | Address word on rising edge (read) |
| mem_sa_fall_o | output | 20 | Address word on falling edge (write) |
| mem_d_rise_o | output | 16 | Write data, rise beat |
| mem_d_fall_o | output | 16 | Write data, fall beat |
| mem_dp_rise_o | output | 2 | Write parity, rise beat |
| mem_dp_fall_o | output | 2 | Write parity, fall beat |
| mem_bw_n_rise_o | output | 2 | Byte-write masks, rise beat, active low |
| mem_bw_n_fall_o | output | 2 | Byte-write masks, fall beat, active low |
| mem_q_rise_i | input | 16 | Read data, rise beat |
| mem_q_fall_i | input | 16 | Read data, fall beat |
| mem_qp_rise_i | input | 2 | Read parity, rise beat |
| mem_qp_fall_i | input | 2 | Read parity, fall beat |

## Verification
The assertions take for granted that the 16-bit and 8-bit qualifiers are never both high on a write. They also assume the memory returns its two read beats exactly MEM_LAT edges after the read strobe. Under those conditions, the mask checks and the bound on outstanding reads are meaningful. The stimulus only ever raises one qualifier at a time. Its SRAM model keys its read pipeline to the memory-side strobe with the same MEM_LAT, so the returned beats always land on the capture edge.

// File: rtl/qdr2_pkg.sv
package qdr2_pkg;
  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2
  } acc_size_e;

  function automatic acc_size_e size_decode(input logic sz16, input logic sz8);
    if (sz8)       return SZ_BYTE;
    else if (sz16) return SZ_HALF;
    else           return SZ_WORD;
  endfunction
endpackage

// File: rtl/qdr2_pipe_stage.sv
module qdr2_pipe_stage #(
  parameter int           W       = 8,
  parameter bit           EN      = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (EN) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VAL;
      else         q <= d_i;
    end
    assign q_o = q;
  end else begin : g_thru
    logic unused_clk_rst;
    assign unused_clk_rst = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/qdr2_wr_path.sv
module qdr2_wr_path
  import qdr2_pkg::*;
#(
  parameter int HADDR_W = 22,
  parameter int BEAT_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_req_i,
  input  logic [HADDR_W-1:0]    wr_addr_i,
  input  logic [2*BEAT_W-1:0]   wr_data_i,
  input  logic [BEAT_W/4-1:0]   wr_par_i,
  input  logic                  sz16_i,
  input  logic                  sz8_i,
  output logic                  mem_wr_n_o,
  output logic [HADDR_W-$clog2(BEAT_W/4)-1:0] mem_sa_fall_o,
  output logic [BEAT_W-1:0]     mem_d_rise_o,
  output logic [BEAT_W-1:0]     mem_d_fall_o,
  output logic [BEAT_W/8-1:0]   mem_dp_rise_o,
  output logic [BEAT_W/8-1:0]   mem_dp_fall_o,
  output logic [BEAT_W/8-1:0]   mem_bw_n_rise_o,
  output logic [BEAT_W/8-1:0]   mem_bw_n_fall_o
);
  localparam int WORD_W  = 2 * BEAT_W;
  localparam int LANES   = WORD_W / 8;
  localparam int BLANES  = BEAT_W / 8;
  localparam int SEL_W   = $clog2(LANES);
  localparam int MADDR_W = HADDR_W - SEL_W;

  acc_size_e          sz;
  logic [LANES-1:0]   lane_en;
  logic               wr_n_q;
  logic [MADDR_W-1:0] sa_q;
  logic [WORD_W-1:0]  d_q;
  logic [LANES-1:0]   p_q;
  logic [LANES-1:0]   bwn_q;

  assign sz = size_decode(sz16_i, sz8_i);

  // lane enables from size and low address bits
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      unique case (sz)
        SZ_WORD: lane_en[i] = 1'b1;
        SZ_HALF: lane_en[i] = ((i >= BLANES) == wr_addr_i[SEL_W-1]);
        SZ_BYTE: lane_en[i] = (SEL_W'(i) == wr_addr_i[SEL_W-1:0]);
        default: lane_en[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_n_q <= 1'b1;
      sa_q   <= '0;
      d_q    <= '0;
      p_q    <= '0;
      bwn_q  <= '1;
    end else if (wr_req_i) begin
      wr_n_q <= 1'b0;
      sa_q   <= wr_addr_i[HADDR_W-1:SEL_W];
      d_q    <= wr_data_i;
      p_q    <= wr_par_i;
      bwn_q  <= ~lane_en;
    end else begin
      wr_n_q <= 1'b1;
      bwn_q  <= '1;
    end
  end

  assign mem_wr_n_o      = wr_n_q;
  assign mem_sa_fall_o   = sa_q;
  assign mem_d_rise_o    = d_q[BEAT_W-1:0];
  assign mem_d_fall_o    = d_q[WORD_W-1:BEAT_W];
  assign mem_dp_rise_o   = p_q[BLANES-1:0];
  assign mem_dp_fall_o   = p_q[LANES-1:BLANES];
  assign mem_bw_n_rise_o = bwn_q[BLANES-1:0];
  assign mem_bw_n_fall_o = bwn_q[LANES-1:BLANES];

  AST_BW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_n_o |-> (&bwn_q));  // R1
  AST_WORD_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_req_i && !sz16_i && !sz8_i) |-> (bwn_q == '0));  // R3
  AST_HALF_ONE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_req_i && sz16_i && !sz8_i) |->
      ($countones(~bwn_q) == BLANES && ((&bwn_q[BLANES-1:0]) || (&bwn_q[LANES-1:BLANES]))));  // R4
  AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_req_i && sz8_i) |-> ($countones(~bwn_q) == 1));  // R5
endmodule

// File: rtl/qdr2_rd_path.sv
module qdr2_rd_path #(
  parameter int HADDR_W = 22,
  parameter int BEAT_W  = 16,
  parameter int MEM_LAT = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_req_i,
  input  logic [HADDR_W-1:0]    rd_addr_i,
  output logic                  mem_rd_n_o,
  output logic [HADDR_W-$clog2(BEAT_W/4)-1:0] mem_sa_rise_o,
  input  logic [BEAT_W-1:0]     mem_q_rise_i,
  input  logic [BEAT_W-1:0]     mem_q_fall_i,
  input  logic [BEAT_W/8-1:0]   mem_qp_rise_i,
  input  logic [BEAT_W/8-1:0]   mem_qp_fall_i,
  output logic [2*BEAT_W-1:0]   rd_data_o,
  output logic [BEAT_W/4-1:0]   par_err_o,
  output logic                  rd_valid_o
);
  localparam int WORD_W  = 2 * BEAT_W;
  localparam int LANES   = WORD_W / 8;
  localparam int SEL_W   = $clog2(LANES);
  localparam int MADDR_W = HADDR_W - SEL_W;
  localparam int CNT_W   = $clog2(MEM_LAT + 2);

  logic               rd_n_q;
  logic [MADDR_W-1:0] sa_q;
  logic [MEM_LAT-1:0] lat_sr;
  logic               cap_en;
  logic [WORD_W-1:0]  word_c;
  logic [LANES-1:0]   par_c;
  logic [LANES-1:0]   err_c;
  logic [WORD_W-1:0]  data_q;
  logic [LANES-1:0]   err_q;
  logic               vld_q;
  logic [CNT_W-1:0]   inflight_q;
  logic               unused_rd_lsb;

  assign unused_rd_lsb = ^rd_addr_i[SEL_W-1:0];
  assign cap_en = lat_sr[MEM_LAT-1];
  assign word_c = {mem_q_fall_i, mem_q_rise_i};
  assign par_c  = {mem_qp_fall_i, mem_qp_rise_i};

  always_comb begin
    for (int i = 0; i < LANES; i++) err_c[i] = (^word_c[8*i +: 8]) ^ par_c[i];
  end

  // issue and latency tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_n_q <= 1'b1;
      sa_q   <= '0;
      lat_sr <= '0;
    end else begin
      rd_n_q <= ~rd_req_i;
      if (rd_req_i) sa_q <= rd_addr_i[HADDR_W-1:SEL_W];
      lat_sr[0] <= rd_req_i;
      for (int i = 1; i < MEM_LAT; i++) lat_sr[i] <= lat_sr[i-1];
    end
  end

  // beat capture and parity check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      err_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= cap_en;
      if (cap_en) begin
        data_q <= word_c;
        err_q  <= err_c;
      end else begin
        err_q  <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CNT_W'(rd_req_i) - CNT_W'(cap_en);
  end

  assign mem_rd_n_o    = rd_n_q;
  assign mem_sa_rise_o = sa_q;
  assign rd_data_o     = data_q;
  assign par_err_o     = err_q;
  assign rd_valid_o    = vld_q;

  AST_INFLIGHT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CNT_W'(MEM_LAT));  // R8
  AST_STROBE_TRACKS_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd_n_o |-> lat_sr[0]);  // R8
  AST_FLAGS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (par_err_o == '0));  // R7
endmodule

// File: rtl/qdr2_bridge.sv
module qdr2_bridge
  import qdr2_pkg::*;
#(
  parameter int HADDR_W   = 22,
  parameter int HDATA_W   = 32,
  parameter int MEM_LAT   = 3,
  parameter bit HOST_PIPE = 1'b1,
  localparam int BEAT_W   = HDATA_W / 2,
  localparam int LANES    = HDATA_W / 8,
  localparam int BLANES   = BEAT_W / 8,
  localparam int MADDR_W  = HADDR_W - $clog2(HDATA_W / 8)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HADDR_W-1:0] host_wr_addr_i,
  input  logic [HADDR_W-1:0] host_rd_addr_i,
  input  logic [HDATA_W-1:0] host_wr_data_i,
  input  logic [LANES-1:0]   host_wr_par_i,
  input  logic               host_rd_n_i,
  input  logic               host_wr_n_i,
  input  logic               host_sz16_i,
  input  logic               host_sz8_i,
  output logic [HDATA_W-1:0] host_rd_data_o,
  output logic [LANES-1:0]   host_par_err_o,
  output logic               host_rd_valid_o,
  output logic               mem_rd_n_o,
  output logic               mem_wr_n_o,
  output logic [MADDR_W-1:0] mem_sa_rise_o,
  output logic [MADDR_W-1:0] mem_sa_fall_o,
  output logic [BEAT_W-1:0]  mem_d_rise_o,
  output logic [BEAT_W-1:0]  mem_d_fall_o,
  output logic [BLANES-1:0]  mem_dp_rise_o,
  output logic [BLANES-1:0]  mem_dp_fall_o,
  output logic [BLANES-1:0]  mem_bw_n_rise_o,
  output logic [BLANES-1:0]  mem_bw_n_fall_o,
  input  logic [BEAT_W-1:0]  mem_q_rise_i,
  input  logic [BEAT_W-1:0]  mem_q_fall_i,
  input  logic [BLANES-1:0]  mem_qp_rise_i,
  input  logic [BLANES-1:0]  mem_qp_fall_i
);
  localparam int IN_W  = 4 + 2 * HADDR_W + HDATA_W + LANES;
  localparam int OUT_W = 1 + HDATA_W + LANES;
  localparam logic [IN_W-1:0] IN_RST = {2'b11, {(IN_W-2){1'b0}}};

  logic [IN_W-1:0]    in_d, in_q;
  logic [OUT_W-1:0]   out_d, out_q;
  logic               c_rd_n, c_wr_n, c_sz16, c_sz8;
  logic [HADDR_W-1:0] c_raddr, c_waddr;
  logic [HDATA_W-1:0] c_wdata;
  logic [LANES-1:0]   c_wpar;
  logic [HDATA_W-1:0] r_data;
  logic [LANES-1:0]   r_err;
  logic               r_vld;

  assign in_d = {host_rd_n_i, host_wr_n_i, host_sz16_i, host_sz8_i,
                 host_rd_addr_i, host_wr_addr_i, host_wr_data_i, host_wr_par_i};

  qdr2_pipe_stage #(.W(IN_W), .EN(HOST_PIPE), .RST_VAL(IN_RST)) u_in_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_d),
    .q_o   (in_q)
  );

  assign {c_rd_n, c_wr_n, c_sz16, c_sz8, c_raddr, c_waddr, c_wdata, c_wpar} = in_q;

  qdr2_wr_path #(.HADDR_W(HADDR_W), .BEAT_W(BEAT_W)) u_wr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_req_i       (~c_wr_n),
    .wr_addr_i      (c_waddr),
    .wr_data_i      (c_wdata),
    .wr_par_i       (c_wpar),
    .sz16_i         (c_sz16),
    .sz8_i          (c_sz8),
    .mem_wr_n_o     (mem_wr_n_o),
    .mem_sa_fall_o  (mem_sa_fall_o),
    .mem_d_rise_o   (mem_d_rise_o),
    .mem_d_fall_o   (mem_d_fall_o),
    .mem_dp_rise_o  (mem_dp_rise_o),
    .mem_dp_fall_o  (mem_dp_fall_o),
    .mem_bw_n_rise_o(mem_bw_n_rise_o),
    .mem_bw_n_fall_o(mem_bw_n_fall_o)
  );

  qdr2_rd_path #(.HADDR_W(HADDR_W), .BEAT_W(BEAT_W), .MEM_LAT(MEM_LAT)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_req_i     (~c_rd_n),
    .rd_addr_i    (c_raddr),
    .mem_rd_n_o   (mem_rd_n_o),
    .mem_sa_rise_o(mem_sa_rise_o),
    .mem_q_rise_i (mem_q_rise_i),
    .mem_q_fall_i (mem_q_fall_i),
    .mem_qp_rise_i(mem_qp_rise_i),
    .mem_qp_fall_i(mem_qp_fall_i),
    .rd_data_o    (r_data),
    .par_err_o    (r_err),
    .rd_valid_o   (r_vld)
  );

  assign out_d = {r_vld, r_data, r_err};

  qdr2_pipe_stage #(.W(OUT_W), .EN(HOST_PIPE), .RST_VAL('0)) u_out_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (out_d),
    .q_o   (out_q)
  );

  assign {host_rd_valid_o, host_rd_data_o, host_par_err_o} = out_q;

  AST_SIZE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!c_wr_n && c_sz16) |-> !c_sz8);  // R5
  AST_HOST_FLAGS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_valid_o |-> (host_par_err_o == '0));  // R7
endmodule

// File: tb/qdr2_bridge_tb_top.sv
module qdr2_bridge_tb_top;
  localparam int MEM_LAT   = 3;
  localparam bit HOST_PIPE = 1'b1;
  localparam int LAT       = MEM_LAT + (HOST_PIPE ? 2 : 0);
  localparam int WD_CYC    = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [21:0] host_wr_addr_i = '0, host_rd_addr_i = '0;
  logic [31:0] host_wr_data_i = '0;
  logic [3:0]  host_wr_par_i = '0;
  logic        host_rd_n_i = 1'b1, host_wr_n_i = 1'b1, host_sz16_i = 1'b0, host_sz8_i = 1'b0;
  logic [31:0] host_rd_data_o;
  logic [3:0]  host_par_err_o;
  logic        host_rd_valid_o;
  logic        mem_rd_n_o, mem_wr_n_o;
  logic [19:0] mem_sa_rise_o, mem_sa_fall_o;
  logic [15:0] mem_d_rise_o, mem_d_fall_o;
  logic [1:0]  mem_dp_rise_o, mem_dp_fall_o, mem_bw_n_rise_o, mem_bw_n_fall_o;
  logic [15:0] mem_q_rise_i = '0, mem_q_fall_i = '0;
  logic [1:0]  mem_qp_rise_i = '0, mem_qp_fall_i = '0;

  always #5 clk_i = ~clk_i;

  qdr2_bridge #(.MEM_LAT(MEM_LAT), .HOST_PIPE(HOST_PIPE)) dut_i (.*);

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // scoreboard items
  typedef struct {
    logic [31:0] d;
    logic [3:0]  e;
    int          cyc;
    bit          both;
  } rd_exp_t;
  typedef struct {
    logic [19:0] a;
    logic [31:0] d;
    logic [3:0]  p;
    logic [3:0]  bw;
    int          sz;
  } wr_exp_t;

  rd_exp_t     rq[$];
  wr_exp_t     wq[$];
  logic [19:0] raq[$];

  // host-level shadow
  logic [31:0] sh_d[int];
  logic [3:0]  sh_p[int];

  function automatic logic [3:0] good_par(input logic [31:0] d);
    return {^d[31:24], ^d[23:16], ^d[15:8], ^d[7:0]};
  endfunction

  function automatic logic [3:0] exp_bw(input bit s16, input bit s8, input logic [1:0] a);
    logic [3:0] m;
    m = 4'b0000;
    if (s8)       begin m = 4'b1111; m[a] = 1'b0; end
    else if (s16) m = a[1] ? 4'b0011 : 4'b1100;
    return m;
  endfunction

  task automatic op(input bit rd, input logic [21:0] ra, input bit wr, input logic [21:0] wa,
                    input logic [31:0] wd, input logic [3:0] wp, input bit s16, input bit s8);
    rd_exp_t r;
    wr_exp_t w;
    int      k;
    @(negedge clk_i);
    host_rd_n_i = !rd; host_rd_addr_i = ra;
    host_wr_n_i = !wr; host_wr_addr_i = wa;
    host_wr_data_i = wd; host_wr_par_i = wp;
    host_sz16_i = s16; host_sz8_i = s8;
    @(posedge clk_i);
    #1;
    if (rd) begin
      k = int'(ra[21:2]);
      r.d = sh_d.exists(k) ? sh_d[k] : 32'h0;
      r.e = (sh_p.exists(k) ? sh_p[k] : 4'h0) ^ good_par(r.d);
      r.cyc = cyc;
      r.both = wr;
      rq.push_back(r);
      raq.push_back(ra[21:2]);
    end
    if (wr) begin
      k = int'(wa[21:2]);
      w.a = wa[21:2]; w.d = wd; w.p = wp;
      w.bw = exp_bw(s16, s8, wa[1:0]);
      w.sz = s8 ? 2 : (s16 ? 1 : 0);
      wq.push_back(w);
      if (!sh_d.exists(k)) begin sh_d[k] = 32'h0; sh_p[k] = 4'h0; end
      for (int j = 0; j < 4; j++)
        if (!w.bw[j]) begin sh_d[k][8*j +: 8] = wd[8*j +: 8]; sh_p[k][j] = wp[j]; end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    host_rd_n_i = 1'b1; host_wr_n_i = 1'b1; host_sz16_i = 1'b0; host_sz8_i = 1'b0;
    repeat (n) @(posedge clk_i);
  endtask

  task automatic wr32(input int word, input logic [31:0] d, input logic [3:0] pflip);
    op(1'b0, '0, 1'b1, 22'(word * 4), d, good_par(d) ^ pflip, 1'b0, 1'b0);
  endtask

  task automatic rd32(input int word);
    op(1'b1, 22'(word * 4), 1'b0, '0, '0, '0, 1'b0, 1'b0);
  endtask

  // SRAM model: 18-bit beats, fixed read latency from the memory strobe
  logic [17:0] mem_r[int];
  bit          pv[MEM_LAT];
  logic [19:0] pa[MEM_LAT];
  initial for (int i = 0; i < MEM_LAT; i++) begin pv[i] = 1'b0; pa[i] = '0; end

  always @(negedge clk_i) begin
    int          k;
    logic [17:0] cur;
    logic [15:0] d;
    logic [1:0]  dp, bw;
    if (mem_wr_n_o === 1'b0) begin
      for (int b = 0; b < 2; b++) begin
        k   = int'(mem_sa_fall_o) * 2 + b;
        cur = mem_r.exists(k) ? mem_r[k] : 18'h0;
        d   = b ? mem_d_fall_o : mem_d_rise_o;
        dp  = b ? mem_dp_fall_o : mem_dp_rise_o;
        bw  = b ? mem_bw_n_fall_o : mem_bw_n_rise_o;
        for (int j = 0; j < 2; j++)
          if (!bw[j]) begin cur[8*j +: 8] = d[8*j +: 8]; cur[16+j] = dp[j]; end
        mem_r[k] = cur;
      end
    end
    for (int i = MEM_LAT - 1; i > 0; i--) begin pv[i] = pv[i-1]; pa[i] = pa[i-1]; end
    pv[0] = (mem_rd_n_o === 1'b0);
    pa[0] = mem_sa_rise_o;
    if (pv[MEM_LAT-1]) begin
      k   = int'(pa[MEM_LAT-1]) * 2;
      cur = mem_r.exists(k) ? mem_r[k] : 18'h0;
      mem_q_rise_i = cur[15:0]; mem_qp_rise_i = cur[17:16];
      cur = mem_r.exists(k + 1) ? mem_r[k+1] : 18'h0;
      mem_q_fall_i = cur[15:0]; mem_qp_fall_i = cur[17:16];
    end else begin
      mem_q_rise_i = '0; mem_q_fall_i = '0; mem_qp_rise_i = '0; mem_qp_fall_i = '0;
    end
  end

  // monitor
  always @(negedge clk_i) begin
    rd_exp_t     r;
    wr_exp_t     w;
    logic [19:0] a;
    if (rst_ni && !done) begin
      if (mem_wr_n_o === 1'b0) begin
        if (wq.size() == 0) chk(1'b0, "R3 unexpected write", 64'(mem_sa_fall_o), 64'h0);
        else begin
          w = wq.pop_front();
          chk(mem_sa_fall_o == w.a, "R2 write address", 64'(mem_sa_fall_o), 64'(w.a));
          chk({mem_d_fall_o, mem_d_rise_o} == w.d, "R3 write data beats",
              64'({mem_d_fall_o, mem_d_rise_o}), 64'(w.d));
          chk({mem_dp_fall_o, mem_dp_rise_o} == w.p, "R3 write parity beats",
              64'({mem_dp_fall_o, mem_dp_rise_o}), 64'(w.p));
          chk({mem_bw_n_fall_o, mem_bw_n_rise_o} == w.bw,
              (w.sz == 0) ? "R3 word masks" : ((w.sz == 1) ? "R4 half masks" : "R5 byte masks"),
              64'({mem_bw_n_fall_o, mem_bw_n_rise_o}), 64'(w.bw));
        end
      end else begin
        chk({mem_bw_n_fall_o, mem_bw_n_rise_o} == 4'hF, "R1 idle masks",
            64'({mem_bw_n_fall_o, mem_bw_n_rise_o}), 64'hF);
      end
      if (mem_rd_n_o === 1'b0) begin
        if (raq.size() == 0) chk(1'b0, "R2 unexpected read", 64'(mem_sa_rise_o), 64'h0);
        else begin
          a = raq.pop_front();
          chk(mem_sa_rise_o == a, "R2 read address", 64'(mem_sa_rise_o), 64'(a));
        end
      end
      if (host_rd_valid_o === 1'b1) begin
        if (rq.size() == 0) chk(1'b0, "R6 unexpected valid", 64'(host_rd_data_o), 64'h0);
        else begin
          r = rq.pop_front();
          chk(host_rd_data_o == r.d, r.both ? "R9 read data beside write" : "R6 read data",
              64'(host_rd_data_o), 64'(r.d));
          chk(host_par_err_o == r.e, "R7 parity flags", 64'(host_par_err_o), 64'(r.e));
          chk(cyc == r.cyc + LAT, "R8 read latency", 64'(cyc - r.cyc), 64'(LAT));
        end
      end else begin
        chk(host_par_err_o == 4'h0, "R7 flags with valid low", 64'(host_par_err_o), 64'h0);
      end
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, WD_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk(mem_rd_n_o === 1'b1 && mem_wr_n_o === 1'b1, "R1 strobes in reset",
        64'({mem_rd_n_o, mem_wr_n_o}), 64'h3);
    chk({mem_bw_n_fall_o, mem_bw_n_rise_o} === 4'hF, "R1 masks in reset",
        64'({mem_bw_n_fall_o, mem_bw_n_rise_o}), 64'hF);
    chk(host_rd_valid_o === 1'b0 && host_par_err_o === 4'h0, "R1 host outputs in reset",
        64'({host_rd_valid_o, host_par_err_o}), 64'h0);
    rst_ni = 1'b1;
    idle(3);
    chk(mem_rd_n_o === 1'b1 && mem_wr_n_o === 1'b1, "R1 strobes after reset",
        64'({mem_rd_n_o, mem_wr_n_o}), 64'h3);

    // R3 full words, some with corrupted parity
    for (int i = 0; i < 8; i++)
      wr32(i, 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101),
           (i == 3) ? 4'b0100 : ((i == 5) ? 4'b1111 : 4'b0000));
    // R4 halfwords into word 20
    op(1'b0, '0, 1'b1, 22'(20 * 4),     32'hAAAA_1234, good_par(32'hAAAA_1234), 1'b1, 1'b0);
    op(1'b0, '0, 1'b1, 22'(20 * 4 + 2), 32'h5678_BBBB, good_par(32'h5678_BBBB), 1'b1, 1'b0);
    // R5 bytes into word 21, one lane at a time
    for (int n = 0; n < 4; n++)
      op(1'b0, '0, 1'b1, 22'(21 * 4 + n), 32'h11 << (8 * n) | (32'hC3C3_C3C3 & ~(32'hFF << (8 * n))),
         4'b1111, 1'b0, 1'b1);
    // partial overwrites of full words
    op(1'b0, '0, 1'b1, 22'(2 * 4 + 1), 32'h0000_EE00, 4'b0000, 1'b0, 1'b1);
    op(1'b0, '0, 1'b1, 22'(4 * 4 + 2), 32'h0F0F_0000, 4'b0000, 1'b1, 1'b0);
    idle(2);

    // R6/R7/R8 reads back to back
    for (int i = 0; i < 8; i++) rd32(i);
    rd32(20);
    rd32(21);
    rd32(30);
    idle(LAT + 3);

    // R9 read and write in the same cycle, then read after write
    op(1'b1, 22'(20 * 4), 1'b1, 22'(40 * 4), 32'hDEAD_BEEF, good_par(32'hDEAD_BEEF), 1'b0, 1'b0);
    op(1'b1, 22'(7 * 4),  1'b1, 22'(41 * 4), 32'h0000_0001, 4'b0000, 1'b0, 1'b0);
    rd32(40);
    rd32(41);
    idle(LAT + 6);

    chk(rq.size() == 0, "R6 pending reads drained", 64'(rq.size()), 64'h0);
    chk(wq.size() == 0 && raq.size() == 0, "R2 pending memory ops drained",
        64'(wq.size() + raq.size()), 64'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule